// File: doc/BRIEF.md
# Per-Pair Queued Packet Crossbar

This block is a square switch fabric that carries packets between NPORT streaming inputs and NPORT streaming outputs. One input typically comes from the network ingress and the remaining ports attach to processing engines. Each packet carries its own destination port number, so a packet can pass through the engines in any sequence chosen hop by hop. A small FIFO sits at every input/output crossing. A packet bound for one output never waits behind traffic for another output.

Each output runs its own scheduler over the column of FIFOs that feed it. No shared arbiter exists. A two-bit policy input selects how an idle output picks its next packet: rotating priority, the fullest queue, or the earliest arrival. Once an output has offered the first word of a packet, it keeps that source until the word marked last has gone out.

Back-pressure rules: an input word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` for an input depends only on the FIFO selected by that input's current `in_dest`, so it may change combinationally with `in_dest`. An output word moves on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the offered word stays unchanged.

Top module: `xbar_xq`

## Requirements
- R1: In the first cycle after reset, every `out_valid` is low, and every `in_ready` is high for an in-range destination.
- R2: Each accepted word appears on the output numbered by its `in_dest`, with data and `last` unchanged. Words of one input/output pair leave in acceptance order. A destination at or above NPORT holds `in_ready` low.
- R3: Once an output has sent a non-last word, every word it sends up to and including the next `last` comes from the same input.
- R4: When the FIFO for (input i, output j) is full, `in_ready[i]` is low only while `in_dest[i]` equals j. Other destinations are still accepted, and no accepted word is ever lost.
- R5: Policy code 0 (rotating): an idle output grants the first non-empty queue after the input it granted last, wrapping from NPORT-1 to 0. After reset the search starts at input 0.
- R6: Policy code 1 (fullest): an idle output grants the queue holding the most words. Ties go to the lowest input index.
- R7: Policy code 2 (earliest): an idle output grants the queue whose head packet's first word was accepted earliest. Ties go to the lowest input index.
- R8: Policy code 3 behaves as code 0. The policy only affects the choice made when an output is between packets.
- R9: A word accepted on one edge by an idle output with no queued traffic is offered on `out_valid` in the cycle right after that edge.
- R10: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with the same data and `last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Scheduler choice: 0 rotate, 1 fullest, 2 earliest, 3 rotate |
| in_valid | input | NPORT | Per-input word valid |
| in_ready | output | NPORT | Per-input accept, depends on that input's destination queue |
| in_data | input | NPORT*DATA_W | Per-input word, input i at bits [i*DATA_W +: DATA_W] |
| in_last | input | NPORT | Marks the final word of a packet |
| in_dest | input | NPORT*DEST_W | Destination output per input; must stay constant across one packet |
| out_valid | output | NPORT | Per-output word valid |
| out_ready | input | NPORT | Per-output sink ready |
| out_data | output | NPORT*DATA_W | Per-output word |
| out_last | output | NPORT | Final word of the packet on that output |

## Verification
A wrong grant register shows up at the ports within one word. Either a word from a second input arrives in the middle of a packet, or the order of packet starts on a pre-loaded output differs from the one the selected policy dictates. A corrupted FIFO pointer or occupancy count shows up as a reordered, repeated or missing sequence number on the output for that pair, or as `in_ready` falling for the wrong destination. The earliest such cue is the first handshake after the fault. Stalled outputs expose any change of the held word in the very next cycle.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  typedef enum logic [1:0] {
    POL_RR   = 2'd0,
    POL_LQF  = 2'd1,
    POL_FCFS = 2'd2,
    POL_RR2  = 2'd3
  } pol_e;
endpackage

// File: rtl/xq_fifo.sv
`timescale 1ns/1ps
module xq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/xq_sched.sv
`timescale 1ns/1ps
module xq_sched
  import xbar_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int CW    = 3,
  parameter int TAG_W = 8,
  parameter int SW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy,
  input  logic [NPORT-1:0]       q_ne,
  input  logic [NPORT*CW-1:0]    q_cnt,
  input  logic [NPORT*TAG_W-1:0] q_tag,
  input  logic [NPORT-1:0]       q_last,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [SW-1:0]          sel,
  output logic [NPORT-1:0]       pop
);
  logic          locked;
  logic [SW-1:0] gnt_q, last_q, pick;

  always_comb begin
    logic             found;
    logic [CW-1:0]    best_c;
    logic [TAG_W-1:0] best_t, diff;
    int               idx;
    found = 1'b0; pick = '0; best_c = '0; best_t = '0; diff = '0; idx = 0;
    case (pol_e'(policy))
      POL_LQF: begin
        for (int i = 0; i < NPORT; i++) begin
          if (q_ne[i] && (!found || q_cnt[i*CW +: CW] > best_c)) begin
            found = 1'b1; pick = SW'(i); best_c = q_cnt[i*CW +: CW];
          end
        end
      end
      POL_FCFS: begin
        for (int i = 0; i < NPORT; i++) begin
          diff = q_tag[i*TAG_W +: TAG_W] - best_t;
          if (q_ne[i] && (!found || diff[TAG_W-1])) begin
            found = 1'b1; pick = SW'(i); best_t = q_tag[i*TAG_W +: TAG_W];
          end
        end
      end
      default: begin
        for (int k = 1; k <= NPORT; k++) begin
          idx = int'(last_q) + k;
          if (idx >= NPORT) idx = idx - NPORT;
          if (!found && q_ne[idx]) begin
            found = 1'b1; pick = SW'(idx);
          end
        end
      end
    endcase
  end

  assign sel       = locked ? gnt_q : pick;
  assign out_valid = q_ne[sel];

  always_comb begin
    pop = '0;
    pop[sel] = out_valid & out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      gnt_q  <= '0;
      last_q <= SW'(NPORT-1);
    end else if (out_valid) begin
      if (out_ready && q_last[sel]) begin
        locked <= 1'b0;
        last_q <= sel;
      end else begin
        locked <= 1'b1;
        gnt_q  <= sel;
      end
    end
  end
endmodule

// File: rtl/xbar_xq.sv
`timescale 1ns/1ps
module xbar_xq #(
  parameter int NPORT  = 7,
  parameter int DATA_W = 512,
  parameter int QDEPTH = 4,
  parameter int TAG_W  = 8,
  parameter int DEST_W = $clog2(NPORT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               policy,
  input  logic [NPORT-1:0]         in_valid,
  output logic [NPORT-1:0]         in_ready,
  input  logic [NPORT*DATA_W-1:0]  in_data,
  input  logic [NPORT-1:0]         in_last,
  input  logic [NPORT*DEST_W-1:0]  in_dest,
  output logic [NPORT-1:0]         out_valid,
  input  logic [NPORT-1:0]         out_ready,
  output logic [NPORT*DATA_W-1:0]  out_data,
  output logic [NPORT-1:0]         out_last
);
  localparam int SW = $clog2(NPORT);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int FW = TAG_W + 1 + DATA_W;

  logic              q_full  [NPORT][NPORT];
  logic              q_empty [NPORT][NPORT];
  logic              q_push  [NPORT][NPORT];
  logic              q_pop   [NPORT][NPORT];
  logic [CW-1:0]     q_cnt   [NPORT][NPORT];
  logic [FW-1:0]     q_rd    [NPORT][NPORT];
  logic [FW-1:0]     q_wr    [NPORT];
  logic [TAG_W-1:0]  tag_cnt;
  logic [TAG_W-1:0]  tag_hold [NPORT];
  logic [NPORT-1:0]  mid_pkt;
  logic [NPORT*SW-1:0] cur_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) tag_cnt <= '0;
    else        tag_cnt <= tag_cnt + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      in_ready[i] = 1'b0;
      for (int j = 0; j < NPORT; j++) begin
        if (in_dest[i*DEST_W +: DEST_W] == DEST_W'(j)) in_ready[i] = !q_full[i][j];
        q_push[i][j] = in_valid[i] && !q_full[i][j] &&
                       (in_dest[i*DEST_W +: DEST_W] == DEST_W'(j));
      end
      q_wr[i] = {(mid_pkt[i] ? tag_hold[i] : tag_cnt), in_last[i], in_data[i*DATA_W +: DATA_W]};
    end
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mid_pkt[gi]  <= 1'b0;
        tag_hold[gi] <= '0;
      end else if (in_valid[gi] && in_ready[gi]) begin
        mid_pkt[gi] <= !in_last[gi];
        if (!mid_pkt[gi]) tag_hold[gi] <= tag_cnt;
      end
    end

    for (genvar gj = 0; gj < NPORT; gj++) begin : g_cell
      xq_fifo #(.W(FW), .DEPTH(QDEPTH), .CW(CW)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(q_push[gi][gj]), .wdata(q_wr[gi]),
        .pop(q_pop[gi][gj]), .rdata(q_rd[gi][gj]),
        .full(q_full[gi][gj]), .empty(q_empty[gi][gj]), .count(q_cnt[gi][gj])
      );
    end
  end

  for (genvar gj = 0; gj < NPORT; gj++) begin : g_out
    logic [NPORT-1:0]       ne_c, last_c, pop_c;
    logic [NPORT*CW-1:0]    cnt_c;
    logic [NPORT*TAG_W-1:0] tag_c;
    logic [SW-1:0]          sel_c;

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_col
      assign ne_c[gi]                 = !q_empty[gi][gj];
      assign last_c[gi]               = q_rd[gi][gj][DATA_W];
      assign cnt_c[gi*CW +: CW]       = q_cnt[gi][gj];
      assign tag_c[gi*TAG_W +: TAG_W] = q_rd[gi][gj][FW-1 -: TAG_W];
      assign q_pop[gi][gj]            = pop_c[gi];
    end

    xq_sched #(.NPORT(NPORT), .CW(CW), .TAG_W(TAG_W), .SW(SW)) u_sch (
      .clk(clk), .rst_n(rst_n), .policy(policy),
      .q_ne(ne_c), .q_cnt(cnt_c), .q_tag(tag_c), .q_last(last_c),
      .out_ready(out_ready[gj]), .out_valid(out_valid[gj]),
      .sel(sel_c), .pop(pop_c)
    );

    assign cur_sel[gj*SW +: SW]          = sel_c;
    assign out_data[gj*DATA_W +: DATA_W] = q_rd[sel_c][gj][DATA_W-1:0];
    assign out_last[gj]                  = q_rd[sel_c][gj][DATA_W];
  end
endmodule

// File: rtl/xbar_xq_chk.sv
`timescale 1ns/1ps
module xbar_xq_chk #(
  parameter int NPORT  = 7,
  parameter int DATA_W = 512,
  parameter int DEST_W = 3,
  parameter int SW     = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        in_valid,
  input logic [NPORT-1:0]        in_ready,
  input logic [NPORT*DEST_W-1:0] in_dest,
  input logic [NPORT-1:0]        out_valid,
  input logic [NPORT-1:0]        out_ready,
  input logic [NPORT*DATA_W-1:0] out_data,
  input logic [NPORT-1:0]        out_last,
  input logic [NPORT*SW-1:0]     cur_sel
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (out_valid == '0));

  for (genvar k = 0; k < NPORT; k++) begin : g_k
    // R2
    dest_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[k] && in_ready[k]) |-> (int'(in_dest[k*DEST_W +: DEST_W]) < NPORT));

    // R10
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && !out_ready[k]) |=>
        (out_valid[k] && $stable(out_data[k*DATA_W +: DATA_W]) && $stable(out_last[k])));

    // R3
    no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && out_ready[k] && !out_last[k]) |=> $stable(cur_sel[k*SW +: SW]));
  end
endmodule

bind xbar_xq xbar_xq_chk #(.NPORT(NPORT), .DATA_W(DATA_W), .DEST_W(DEST_W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .cur_sel(cur_sel)
);

// File: tb/sim_xbar_xq.sv
`timescale 1ns/1ps
module sim_xbar_xq;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int DWD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic [NP-1:0] in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [NP*DW-1:0] in_data, out_data;
  logic [NP*DWD-1:0] in_dest;

  logic          iv [NP];
  logic [DW-1:0] idata [NP];
  logic          il [NP];
  logic [DWD-1:0] idst [NP];
  logic          ordy [NP];

  int nchk = 0, nerr = 0;
  int tx = 0, rx = 0;
  int sent_pid [NP][NP];
  int exp_pid  [NP][NP];
  int busy [NP], csrc [NP], cw [NP], ocnt [NP];
  int ord [NP][16];
  bit rnd_on = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = iv[i];
      in_data[i*DW +: DW] = idata[i];
      in_last[i] = il[i];
      in_dest[i*DWD +: DWD] = idst[i];
      out_ready[i] = ordy[i];
    end
  end

  xbar_xq #(.NPORT(NP), .DATA_W(DW), .QDEPTH(4), .TAG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(input int s, input int d, input int p, input int w, input int n);
    return {4'(s), 4'(d), 8'(p), 8'(w), 8'(n)};
  endfunction

  task automatic send_pkt(input int s, input int d, input int n);
    int p;
    bit acc;
    p = sent_pid[s][d];
    sent_pid[s][d] = (p + 1) % 256;
    tx++;
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      iv[s] = 1'b1; idst[s] = DWD'(d); il[s] = (w == n-1);
      idata[s] = enc(s, d, p, w, n);
      do begin
        #5 acc = in_ready[s];
        if (!acc) @(negedge clk);
      end while (!acc);
    end
    @(negedge clk);
    iv[s] = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    while (rx < target) @(negedge clk);
  endtask

  // Output monitor: routing, ordering, framing per output
  logic [DW-1:0] md;
  int ms, mw, mn, mp;
  always begin
    @(negedge clk);
    #5;
    for (int j = 0; j < NP; j++) begin
      if (rst_n && out_valid[j] && ordy[j]) begin
        md = out_data[j*DW +: DW];
        ms = int'(md[31:28]); mp = int'(md[23:16]); mw = int'(md[15:8]); mn = int'(md[7:0]);
        chk(int'(md[27:24]) == j, "R2 dest", int'(md[27:24]), j);
        chk(out_last[j] == (mw == mn-1), "R2 last", int'(out_last[j]), int'(mw == mn-1));
        if (busy[j] != 0) begin
          chk(ms == csrc[j], "R3 source", ms, csrc[j]);
          chk(mw == cw[j], "R3 word", mw, cw[j]);
        end else begin
          chk(mw == 0, "R3 start", mw, 0);
          chk(mp == exp_pid[ms][j], "R2 order", mp, exp_pid[ms][j]);
          exp_pid[ms][j] = (exp_pid[ms][j] + 1) % 256;
          csrc[j] = ms;
          if (ocnt[j] < 16) begin ord[j][ocnt[j]] = ms; ocnt[j]++; end
        end
        cw[j] = mw + 1;
        busy[j] = out_last[j] ? 0 : 1;
        if (out_last[j]) rx++;
      end
    end
  end

  always begin
    @(negedge clk);
    if (rnd_on) for (int j = 0; j < NP; j++) ordy[j] = ($urandom % 4) != 0;
  end

  task automatic order_test(input int pol, input string req,
                            input int bs, input int bn,
                            input int s0, input int n0, input int s1, input int n1,
                            input int s2, input int n2,
                            input int e0, input int e1, input int e2, input int e3);
    int e [4];
    e = '{e0, e1, e2, e3};
    @(negedge clk);
    policy = 2'(pol); ordy[0] = 1'b0; ocnt[0] = 0;
    send_pkt(bs, 0, bn);
    send_pkt(s0, 0, n0);
    send_pkt(s1, 0, n1);
    send_pkt(s2, 0, n2);
    @(negedge clk);
    ordy[0] = 1'b1;
    wait_rx(tx);
    for (int k = 0; k < 4; k++) chk(ord[0][k] == e[k], req, ord[0][k], e[k]);
  endtask

  task automatic fin;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", rx, tx);
    fin();
  end

  initial begin
    logic [DW-1:0] ex;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NP; i++) begin
      iv[i] = 0; idata[i] = '0; il[i] = 0; idst[i] = '0; ordy[i] = 0;
      busy[i] = 0; csrc[i] = 0; cw[i] = 0; ocnt[i] = 0;
      for (int j = 0; j < NP; j++) begin sent_pid[i][j] = 0; exp_pid[i][j] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1
    chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready", int'(in_ready), 15);

    // R9: single word, idle output, offered one cycle after acceptance
    for (int i = 0; i < NP; i++) ordy[i] = 1'b1;
    @(negedge clk);
    ex = enc(1, 2, sent_pid[1][2], 0, 1);
    sent_pid[1][2]++; tx++;
    iv[1] = 1; idst[1] = 2; il[1] = 1; idata[1] = ex;
    #5 chk(in_ready[1], "R9 accept", int'(in_ready[1]), 1);
    chk(!out_valid[2], "R9 before", int'(out_valid[2]), 0);
    @(negedge clk);
    iv[1] = 0;
    #5 chk(out_valid[2], "R9 latency", int'(out_valid[2]), 1);
    chk(out_data[2*DW +: DW] == ex, "R9 data", int'(out_data[2*DW +: DW]), int'(ex));
    wait_rx(tx);

    // R5: blocker from 2, then 3,0,1 queued -> rotate from 3
    order_test(0, "R5 rotate", 2, 2, 3, 1, 0, 1, 1, 1, 2, 3, 0, 1);
    // R6: fullest first, tie to lowest index
    order_test(1, "R6 fullest", 3, 1, 0, 1, 1, 3, 2, 3, 3, 1, 2, 0);
    // R7: earliest arrival first
    order_test(2, "R7 earliest", 0, 1, 3, 2, 2, 1, 1, 3, 0, 3, 2, 1);
    // R8: code 3 rotates like code 0 (fullest would give 0,1,3)
    order_test(3, "R8 code3", 2, 2, 3, 1, 0, 1, 1, 1, 2, 3, 0, 1);

    // R4: fill pair (1,0), check per-destination back-pressure
    @(negedge clk);
    policy = 0; ordy[0] = 0;
    send_pkt(1, 0, 4);
    @(negedge clk);
    iv[1] = 1; idst[1] = 0; il[1] = 1; idata[1] = enc(1, 0, 99, 0, 1);
    #5 chk(!in_ready[1], "R4 full blocks", int'(in_ready[1]), 0);
    chk(in_ready[2], "R4 other input", int'(in_ready[2]), 1);
    @(negedge clk);
    ex = enc(1, 3, sent_pid[1][3], 0, 1);
    sent_pid[1][3]++; tx++;
    idst[1] = 3; idata[1] = ex;
    #5 chk(in_ready[1], "R4 other dest", int'(in_ready[1]), 1);
    @(negedge clk);
    iv[1] = 0;
    wait_rx(tx - 1);
    chk(!out_valid[0] || !ordy[0], "R4 held", int'(ordy[0]), 0);
    ordy[0] = 1;
    wait_rx(tx);
    chk(rx == tx, "R4 no loss", rx, tx);

    // Random traffic under each policy
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      policy = 2'(r);
      rnd_on = 1'b1;
      for (int i = 0; i < NP; i++) begin
        automatic int ii = i;
        fork
          for (int k = 0; k < 25; k++) send_pkt(ii, int'($urandom % NP), 1 + int'($urandom % 6));
        join_none
      end
      wait fork;
      rnd_on = 1'b0;
      @(negedge clk);
      for (int j = 0; j < NP; j++) ordy[j] = 1'b1;
      wait_rx(tx);
      chk(rx == tx, "R2 random delivery", rx, tx);
    end
    repeat (4) @(negedge clk);
    chk(out_valid == '0, "R4 drained", int'(out_valid), 0);
    fin();
  end
endmodule